// File: doc/BRIEF.md
# Doorbell-Woken Transfer Ring Consumer

This block is the device-side engine that drains work rings kept in host memory. Every channel owns a circular ring given by a base address, a length in elements, a read index and a write index. The host fills ring elements, moves the channel's write index forward and then strikes that channel's doorbell. Only after the doorbell does the engine fetch elements at the read index through a one-outstanding memory read port. It joins elements linked by a chain flag into one descriptor and reports one completion notice per descriptor. The notice carries the channel number and the total byte count.

Each accepted doorbell stores the write index present at that moment as the channel's service target. A channel is eligible while its read index differs from its target. Eligible channels are granted round-robin, and each grant covers exactly one descriptor. A doorbell to a disabled channel, or to a channel whose ring is empty, changes nothing except a sticky per-channel error bit. If a chain runs up to the target with its flag still set, the descriptor is closed at that boundary and reported.

Top module: `ring_consumer`

## Requirements
- R1: After reset there is no memory request and no completion notice, and every error bit reads 0.
- R2: Configuration writes select a field with `cfg_sel`: 0 base address, 1 ring length (this also rewinds read index and target to 0), 2 write index, 3 enable (data bit 0). Advancing the write index without a doorbell causes no memory request.
- R3: A descriptor made of one element is fetched from address base + index*8. The element holds buffer pointer in bits 31:0, byte size in bits 47:32 and chain flag in bit 48. The descriptor yields one notice with the channel number and that size.
- R4: Elements whose chain flag is 1 are joined with the following elements. Exactly one notice is produced, after the element whose chain flag is 0, and it carries the sum of the sizes.
- R5: After the element at index length-1, the read index moves to index 0, so a chain may span the wrap point.
- R6: A doorbell struck while the channel still has work merges with it. Service runs until the read index equals the write index captured at the latest doorbell.
- R7: When several channels are eligible, grants rotate round-robin starting after the last granted channel. Each grant services exactly one descriptor.
- R8: A doorbell to a channel whose enable is 0 issues no request and sets that channel's bit in `err_o`.
- R9: A doorbell to a channel whose write index equals its read index (empty ring) issues no request and sets that channel's bit in `err_o`. Error bits stay set until reset.
- R10: A ring holding length-1 unserviced elements (write index + 1 == read index modulo length, the full state) is drained completely.
- R11: A memory request not yet accepted keeps its valid high and its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_ID_W | Channel addressed by the configuration write |
| cfg_sel | input | 2 | Field select: 0 base, 1 length, 2 write index, 3 enable |
| cfg_data | input | AW | Configuration write data |
| db_valid | input | 1 | Doorbell strike |
| db_ch | input | CH_ID_W | Channel whose doorbell is struck |
| mem_req_valid | output | 1 | Element read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | AW | Byte address of the element |
| mem_rsp_valid | input | 1 | Element data returned |
| mem_rsp_data | input | 64 | Returned element |
| cpl_valid | output | 1 | One-cycle completion notice |
| cpl_ch | output | CH_ID_W | Channel of the finished descriptor |
| cpl_bytes | output | CNT_W | Summed byte count of the descriptor |
| err_o | output | NCH | Sticky per-channel doorbell error bits |

## Verification
Some properties are checked on every cycle: a request is only issued for a channel whose read index has not reached its target, a pending request holds its address, notices never come on back-to-back cycles, at most one channel is granted, and error bits never clear. The bench scenarios are needed for everything that depends on data: summed byte counts over chains and over the wrap point, merging of a second doorbell, the round-robin order across three channels, draining a full ring, and doorbells that are refused. A behavioural model with per-channel queues predicts every notice and the error vector on each clock.

// File: rtl/ring_consumer_pkg.sv
package ring_consumer_pkg;
   timeunit 1ns; timeprecision 100ps;

   // element layout as seen on the response bus
   localparam int EL_W        = 64;
   localparam int EL_PTR_W    = 32;
   localparam int EL_SIZE_W   = 16;
   localparam int EL_CHAIN    = EL_PTR_W + EL_SIZE_W;
   localparam int EL_BYTES_LG = 3;

   typedef struct packed {
      logic                 chain;
      logic [EL_SIZE_W-1:0] size;
      logic [EL_PTR_W-1:0]  ptr;
   } elem_t;

   typedef enum logic [1:0] {
      CFG_BASE   = 2'd0,
      CFG_LEN    = 2'd1,
      CFG_WIDX   = 2'd2,
      CFG_ENABLE = 2'd3
   } cfg_sel_e;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_ISSUE = 2'd1,
      FS_WAIT  = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/rcq_chan.sv
module rcq_chan
   import ring_consumer_pkg::*;
#(
   parameter int AW    = 32,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_hit,
   input  logic [1:0]       cfg_sel,
   input  logic [AW-1:0]    cfg_data,
   input  logic             db_hit,
   input  logic             adv,
   output logic [AW-1:0]    base_o,
   output logic [IDX_W-1:0] rp_o,
   output logic [IDX_W-1:0] rp_nxt_o,
   output logic [IDX_W-1:0] tgt_o,
   output logic             elig_o,
   output logic             err_o
);
   timeunit 1ns; timeprecision 100ps;

   logic [AW-1:0]    base_q;
   logic [IDX_W-1:0] len_q, widx_q, rp_q, tgt_q;
   logic             en_q, err_q;
   logic             db_ok;

   // wrap after the last programmed slot
   assign rp_nxt_o = (rp_q == len_q - 1'b1) ? '0 : rp_q + 1'b1;
   assign db_ok    = en_q && (widx_q != rp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         widx_q <= '0;
         rp_q   <= '0;
         tgt_q  <= '0;
         en_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (adv)
            rp_q <= rp_nxt_o;
         if (db_hit) begin
            if (db_ok)
               tgt_q <= widx_q;
            else
               err_q <= 1'b1;
         end
         if (cfg_hit) begin
            case (cfg_sel_e'(cfg_sel))
               CFG_BASE:   base_q <= cfg_data;
               CFG_LEN: begin
                  len_q <= cfg_data[IDX_W-1:0];
                  rp_q  <= '0;
                  tgt_q <= '0;
               end
               CFG_WIDX:   widx_q <= cfg_data[IDX_W-1:0];
               CFG_ENABLE: en_q   <= cfg_data[0];
               default:    ;
            endcase
         end
      end
   end

   assign base_o = base_q;
   assign rp_o   = rp_q;
   assign tgt_o  = tgt_q;
   assign elig_o = (rp_q != tgt_q);
   assign err_o  = err_q;
endmodule

// File: rtl/rcq_rr_arb.sv
module rcq_rr_arb #(
   parameter int NCH = 4,
   parameter int CW  = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req,
   input  logic           take,
   output logic [CW-1:0]  gnt_idx,
   output logic [NCH-1:0] gnt_vec,
   output logic           any
);
   timeunit 1ns; timeprecision 100ps;

   logic [CW-1:0] last_q;
   logic          found;

   always_comb begin
      gnt_idx = '0;
      gnt_vec = '0;
      found   = 1'b0;
      for (int k = 1; k <= NCH; k++) begin
         if (!found && req[(int'(last_q) + k) % NCH]) begin
            found   = 1'b1;
            gnt_idx = CW'((int'(last_q) + k) % NCH);
            gnt_vec[(int'(last_q) + k) % NCH] = 1'b1;
         end
      end
      any = found;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_q <= CW'(NCH - 1);
      else if (take && found)
         last_q <= gnt_idx;
   end
endmodule

// File: rtl/rcq_fetch.sv
module rcq_fetch
   import ring_consumer_pkg::*;
#(
   parameter int CW    = 2,
   parameter int AW    = 32,
   parameter int IDX_W = 8,
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any,
   input  logic [CW-1:0]    gnt_idx,
   output logic             take,
   output logic [CW-1:0]    cur_ch,
   input  logic [AW-1:0]    cur_base,
   input  logic [IDX_W-1:0] cur_rp,
   input  logic [IDX_W-1:0] cur_rp_nxt,
   input  logic [IDX_W-1:0] cur_tgt,
   output logic             mem_req_valid,
   output logic [AW-1:0]    mem_req_addr,
   input  logic             mem_req_ready,
   input  logic             mem_rsp_valid,
   input  logic [EL_W-1:0]  mem_rsp_data,
   output logic             adv,
   output logic             cpl_valid,
   output logic [CW-1:0]    cpl_ch,
   output logic [CNT_W-1:0] cpl_bytes
);
   timeunit 1ns; timeprecision 100ps;

   fetch_state_e     st_q;
   logic [CW-1:0]    ch_q;
   logic [CNT_W-1:0] acc_q, sum;
   elem_t            el;
   logic             last_el;
   logic             unused_bits;

   assign el          = elem_t'(mem_rsp_data[EL_CHAIN:0]);
   assign unused_bits = ^{mem_rsp_data[EL_W-1:EL_CHAIN+1], el.ptr};
   assign sum         = acc_q + CNT_W'(el.size);
   // chain ends on a clear flag or on the posted boundary
   assign last_el     = !el.chain || (cur_rp_nxt == cur_tgt);

   assign take          = (st_q == FS_IDLE) && any;
   assign cur_ch        = ch_q;
   assign mem_req_valid = (st_q == FS_ISSUE);
   assign mem_req_addr  = cur_base + (AW'(cur_rp) << EL_BYTES_LG);
   assign adv           = (st_q == FS_WAIT) && mem_rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FS_IDLE;
         ch_q      <= '0;
         acc_q     <= '0;
         cpl_valid <= 1'b0;
         cpl_ch    <= '0;
         cpl_bytes <= '0;
      end else begin
         cpl_valid <= 1'b0;
         case (st_q)
            FS_IDLE: if (any) begin
               ch_q  <= gnt_idx;
               acc_q <= '0;
               st_q  <= FS_ISSUE;
            end
            FS_ISSUE: if (mem_req_ready)
               st_q <= FS_WAIT;
            FS_WAIT: if (mem_rsp_valid) begin
               if (last_el) begin
                  cpl_valid <= 1'b1;
                  cpl_ch    <= ch_q;
                  cpl_bytes <= sum;
                  st_q      <= FS_IDLE;
               end else begin
                  acc_q <= sum;
                  st_q  <= FS_ISSUE;
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ring_consumer.sv
module ring_consumer
   import ring_consumer_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int CH_ID_W = 8,
   parameter int AW      = 32,
   parameter int IDX_W   = 8,
   parameter int CNT_W   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CH_ID_W-1:0] cfg_ch,
   input  logic [1:0]         cfg_sel,
   input  logic [AW-1:0]      cfg_data,
   input  logic               db_valid,
   input  logic [CH_ID_W-1:0] db_ch,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [AW-1:0]      mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [63:0]        mem_rsp_data,
   output logic               cpl_valid,
   output logic [CH_ID_W-1:0] cpl_ch,
   output logic [CNT_W-1:0]   cpl_bytes,
   output logic [NCH-1:0]     err_o
);
   timeunit 1ns; timeprecision 100ps;

   localparam int CW = $clog2(NCH);

   if (NCH < 2 || NCH > (1 << CH_ID_W) || NCH > 256) begin : g_bad_nch
      $error("ring_consumer: NCH out of range");
   end
   if (AW < IDX_W || AW < EL_BYTES_LG + IDX_W) begin : g_bad_aw
      $error("ring_consumer: AW too narrow");
   end
   if (CNT_W < EL_SIZE_W || EL_W != 64) begin : g_bad_cnt
      $error("ring_consumer: count or element width mismatch");
   end

   logic [AW-1:0]    base_a   [NCH];
   logic [IDX_W-1:0] rp_a     [NCH];
   logic [IDX_W-1:0] rp_nxt_a [NCH];
   logic [IDX_W-1:0] tgt_a    [NCH];
   logic [NCH-1:0]   elig;
   logic [NCH-1:0]   gnt_vec;
   logic [CW-1:0]    gnt_idx, cur_ch, cpl_ch_w;
   logic             any, take, adv;
   logic [AW-1:0]    cur_base;
   logic [IDX_W-1:0] cur_rp, cur_rp_nxt, cur_tgt;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      rcq_chan #(.AW(AW), .IDX_W(IDX_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_hit  (cfg_we && (cfg_ch == CH_ID_W'(i))),
         .cfg_sel  (cfg_sel),
         .cfg_data (cfg_data),
         .db_hit   (db_valid && (db_ch == CH_ID_W'(i))),
         .adv      (adv && (cur_ch == CW'(i))),
         .base_o   (base_a[i]),
         .rp_o     (rp_a[i]),
         .rp_nxt_o (rp_nxt_a[i]),
         .tgt_o    (tgt_a[i]),
         .elig_o   (elig[i]),
         .err_o    (err_o[i])
      );
   end

   assign cur_base   = base_a[cur_ch];
   assign cur_rp     = rp_a[cur_ch];
   assign cur_rp_nxt = rp_nxt_a[cur_ch];
   assign cur_tgt    = tgt_a[cur_ch];

   rcq_rr_arb #(.NCH(NCH), .CW(CW)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (elig),
      .take    (take),
      .gnt_idx (gnt_idx),
      .gnt_vec (gnt_vec),
      .any     (any)
   );

   rcq_fetch #(.CW(CW), .AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fetch (
      .clk           (clk),
      .rst_n         (rst_n),
      .any           (any),
      .gnt_idx       (gnt_idx),
      .take          (take),
      .cur_ch        (cur_ch),
      .cur_base      (cur_base),
      .cur_rp        (cur_rp),
      .cur_rp_nxt    (cur_rp_nxt),
      .cur_tgt       (cur_tgt),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .adv           (adv),
      .cpl_valid     (cpl_valid),
      .cpl_ch        (cpl_ch_w),
      .cpl_bytes     (cpl_bytes)
   );

   assign cpl_ch = CH_ID_W'(cpl_ch_w);
endmodule

// File: rtl/rcq_checker.sv
module rcq_checker #(
   parameter int NCH   = 4,
   parameter int AW    = 32,
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [AW-1:0]    mem_req_addr,
   input logic             cpl_valid,
   input logic [NCH-1:0]   err_o,
   input logic [NCH-1:0]   gnt_vec,
   input logic [IDX_W-1:0] cur_rp,
   input logic [IDX_W-1:0] cur_tgt
);
   timeunit 1ns; timeprecision 100ps;

   // R2: a fetch is only issued while the served channel has posted work
   a_r2_req_has_work: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (cur_rp != cur_tgt));

   // R11: a waiting request keeps valid and address
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R4: one notice per descriptor, never two in a row
   a_r4_single_notice: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |=> !cpl_valid);

   // R9: error bits never clear
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o & $past(err_o)) == $past(err_o));

   // R7: at most one channel granted
   a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_vec));
endmodule

bind ring_consumer rcq_checker #(.NCH(NCH), .AW(AW), .IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .cpl_valid     (cpl_valid),
   .err_o         (err_o),
   .gnt_vec       (gnt_vec),
   .cur_rp        (cur_rp),
   .cur_tgt       (cur_tgt)
);

// File: tb/ring_consumer_test.sv
module ring_consumer_test;
   timeunit 1ns; timeprecision 100ps;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_ch = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_data = '0;
   logic        db_valid = 1'b0;
   logic [7:0]  db_ch = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        cpl_valid;
   logic [7:0]  cpl_ch;
   logic [23:0] cpl_bytes;
   logic [NCH-1:0] err_o;

   ring_consumer uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .db_valid(db_valid),
      .db_ch(db_ch), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .cpl_valid(cpl_valid), .cpl_ch(cpl_ch), .cpl_bytes(cpl_bytes),
      .err_o(err_o)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int req_seen = 0;
   int mlast = NCH - 1;
   logic [NCH-1:0] model_err = '0;
   string cur_req = "R1";
   int exp_q [NCH][$];
   logic [63:0] mem [int];
   bit done = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic int base_of(int c);
      return 32'h1000 * (c + 1);
   endfunction

   function automatic int rr_pick();
      for (int k = 1; k <= NCH; k++)
         if (exp_q[(mlast + k) % NCH].size() > 0) return (mlast + k) % NCH;
      return -1;
   endfunction

   // memory: one response the cycle after acceptance
   initial begin
      forever begin
         bit hit;
         int a;
         @(negedge clk);
         hit = mem_req_valid && mem_req_ready;
         a = int'(mem_req_addr);
         @(posedge clk);
         #1;
         mem_rsp_valid = hit;
         mem_rsp_data  = (hit && mem.exists(a)) ? mem[a] : 64'd0;
      end
   end

   // per-clock comparison against the model
   initial begin
      forever begin
         @(negedge clk);
         cycles++;
         if (mem_req_valid) req_seen++;
         if (rst_n) begin
            chk(err_o == model_err, "R8/R9", "err_o", err_o, model_err);
            if (cpl_valid) begin
               int c;
               c = rr_pick();
               if (c < 0) begin
                  chk(0, cur_req, "unexpected notice channel", cpl_ch, -1);
               end else begin
                  chk(cpl_ch == c, cur_req, "notice channel", cpl_ch, c);
                  chk(cpl_bytes == exp_q[c][0], cur_req, "notice bytes",
                      cpl_bytes, exp_q[c][0]);
                  void'(exp_q[c].pop_front());
                  mlast = c;
               end
            end
         end
         if (cycles > 100000) begin
            chk(0, "watchdog", "cycles", cycles, 100000);
            finish_run();
         end
      end
   end

   task automatic cfg(int c, int sel, int data);
      @(posedge clk); #1;
      cfg_we = 1; cfg_ch = 8'(c); cfg_sel = 2'(sel); cfg_data = data;
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic ring(int c, bit valid_expected);
      @(posedge clk); #1;
      db_valid = 1; db_ch = 8'(c);
      @(posedge clk); #1;
      db_valid = 0;
      if (!valid_expected) model_err[c] = 1'b1;
   endtask

   task automatic put(int c, int idx, int size, bit chain);
      mem[base_of(c) + idx * 8] = {15'd0, chain, 16'(size), 32'hA000_0000 + 32'(idx)};
   endtask

   task automatic drain(string tag);
      int left;
      for (int n = 0; n < 400; n++) begin
         left = 0;
         for (int c = 0; c < NCH; c++) left += exp_q[c].size();
         if (left == 0) break;
         @(negedge clk);
      end
      left = 0;
      for (int c = 0; c < NCH; c++) left += exp_q[c].size();
      chk(left == 0, tag, "descriptors left", left, 0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int r0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(mem_req_valid == 0, "R1", "req_valid after reset", mem_req_valid, 0);
      chk(cpl_valid == 0, "R1", "cpl_valid after reset", cpl_valid, 0);
      chk(err_o == 0, "R1", "err_o after reset", err_o, 0);

      for (int c = 0; c < NCH; c++) begin
         cfg(c, 0, base_of(c));
         cfg(c, 1, 8);
         if (c != 3) cfg(c, 3, 1);
      end

      // R2: write index alone does nothing
      cur_req = "R2";
      put(0, 0, 100, 0);
      r0 = req_seen;
      cfg(0, 2, 1);
      repeat (10) @(negedge clk);
      chk(req_seen == r0, "R2", "requests without doorbell", req_seen - r0, 0);
      // R3: single element descriptor
      cur_req = "R3";
      exp_q[0].push_back(100);
      ring(0, 1);
      drain("R3");

      // R4: three chained elements give one summed notice
      cur_req = "R4";
      put(1, 0, 10, 1); put(1, 1, 20, 1); put(1, 2, 30, 0);
      cfg(1, 2, 3);
      exp_q[1].push_back(60);
      ring(1, 1);
      drain("R4");

      // R8: disabled channel
      cur_req = "R8";
      put(3, 0, 7, 0);
      cfg(3, 2, 1);
      r0 = req_seen;
      ring(3, 0);
      repeat (8) @(negedge clk);
      chk(req_seen == r0, "R8", "requests after refused doorbell", req_seen - r0, 0);
      chk(err_o[3] == 1, "R8", "err bit 3", err_o[3], 1);

      // R9: empty ring
      cur_req = "R9";
      r0 = req_seen;
      ring(1, 0);
      repeat (8) @(negedge clk);
      chk(req_seen == r0, "R9", "requests after empty doorbell", req_seen - r0, 0);
      chk(err_o[1] == 1, "R9", "err bit 1", err_o[1], 1);

      // R7: round-robin over three channels, one descriptor per grant
      cur_req = "R7";
      @(posedge clk); #1 mem_req_ready = 0;
      put(2, 0, 9, 0);  put(2, 1, 11, 0);
      put(0, 1, 5, 0);  put(0, 2, 6, 0);
      put(1, 3, 7, 0);  put(1, 4, 8, 0);
      cfg(2, 2, 2); cfg(0, 2, 3); cfg(1, 2, 5);
      exp_q[2].push_back(9); exp_q[2].push_back(11);
      exp_q[0].push_back(5); exp_q[0].push_back(6);
      exp_q[1].push_back(7); exp_q[1].push_back(8);
      ring(2, 1); ring(0, 1); ring(1, 1);
      repeat (3) @(negedge clk);
      // R11: held request
      chk(mem_req_valid == 1, "R11", "req held valid", mem_req_valid, 1);
      chk(mem_req_addr == 32'(base_of(2)), "R11", "held addr", mem_req_addr, base_of(2));
      @(posedge clk); #1 mem_req_ready = 1;
      drain("R7");

      // R6: second doorbell merges with pending work
      cur_req = "R6";
      @(posedge clk); #1 mem_req_ready = 0;
      put(0, 3, 40, 0);
      cfg(0, 2, 4);
      exp_q[0].push_back(40);
      ring(0, 1);
      put(0, 4, 41, 0);
      cfg(0, 2, 5);
      exp_q[0].push_back(41);
      ring(0, 1);
      @(posedge clk); #1 mem_req_ready = 1;
      drain("R6");

      // R10: full ring of length 4 holds three elements
      cur_req = "R10";
      cfg(2, 1, 4);
      put(2, 0, 1, 0); put(2, 1, 2, 0); put(2, 2, 3, 0);
      cfg(2, 2, 3);
      exp_q[2].push_back(1); exp_q[2].push_back(2); exp_q[2].push_back(3);
      ring(2, 1);
      drain("R10");

      // R5: chain crosses the wrap point; slot 4 holds a decoy
      cur_req = "R5";
      put(2, 3, 50, 1); put(2, 0, 60, 0); put(2, 4, 999, 0);
      cfg(2, 2, 1);
      exp_q[2].push_back(110);
      ring(2, 1);
      drain("R5");

      finish_run();
   end
endmodule